// File: doc/BRIEF.md
# Control-Word Register-File Datapath

This block is an 8-bit datapath built from seven general registers, two source buses, an ALU and a destination decoder. Every clock cycle it performs exactly one micro-operation described by a 14-bit control word. The word names the register (or the external input) that drives each source bus, the function the ALU applies, and the register that captures the result at the next rising clock edge.

The external input can stand in for either source operand. The ALU result is always visible on the output port, combinationally from the current word and register contents. A destination code of zero suppresses the write, so a word can be used purely to read a register or to pass the input straight through. A controller outside this block issues the sequence of words. This block holds no flags and does no sequencing of its own.

Top module: `cw_datapath`

## Requirements
- R1: The control word packs four fields. Bits [13:11] select the A source, bits [10:8] the B source, bits [7:5] the destination, and bits [4:0] the ALU function.
- R2: On either source field, code 0 puts `ext_in` on that bus. Codes 1 to 7 put register Rk (k = code) on that bus.
- R3: A destination code k in 1..7 loads the ALU result into Rk at the rising clock edge, and every other register keeps its value. Destination code 0 writes no register.
- R4: The arithmetic functions work modulo 2^8: 00000 passes A, 00001 gives A+1, 00010 gives A+B, 00101 gives A−B and 00110 gives A−1.
- R5: The bitwise functions are 01000 A AND B, 01010 A OR B, 01100 A XOR B and 01110 NOT A.
- R6: Function 10000 shifts A right by one and function 11000 shifts A left by one. In both cases the vacated bit is filled with 0.
- R7: Any function code not listed in R4 to R6 drives zero on the result.
- R8: `result_out` carries the ALU result on every cycle, including cycles whose destination code is 0.
- R9: After reset all seven registers read zero. Reset is asynchronous and active low, and its release is synchronised to `clk`.
- R10: A word that names the same register as A, B and destination, with function XOR, clears that register. For example, word 101_101_101_01100 sets R5 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers load on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 14 | Micro-operation: A source, B source, destination, function |
| ext_in | input | 8 | External operand, selectable as either source |
| result_out | output | 8 | ALU result of the current micro-operation |

## Verification
The bench pushes the ALU to its wrap points: 0xFF plus one, zero minus one, and a subtraction that borrows. A design with a wrong operand order or a truncation slip would then show a wrong value on the output. Shifts use patterns with both end bits set, so a rotate or a sign fill in place of a zero fill shows up. It drives unlisted function codes next to listed ones, so an ALU that decodes only part of the function field and aliases codes would return a non-zero result. It issues destination-0 words and the same-register XOR clear, then reads back all seven registers. This exposes a decoder that writes R0's alias, writes the wrong neighbour, or leaves a stale value.

// File: rtl/cw_dp_pkg.sv
package cw_dp_pkg;

  localparam int unsigned SEL_W = 3;
  localparam int unsigned FN_W  = 5;
  localparam int unsigned CW_W  = 3 * SEL_W + FN_W;
  localparam int unsigned NREG  = (1 << SEL_W) - 1;

  // field positions inside the control word
  localparam int unsigned A_LSB  = CW_W - SEL_W;
  localparam int unsigned B_LSB  = A_LSB - SEL_W;
  localparam int unsigned D_LSB  = B_LSB - SEL_W;

  typedef enum logic [FN_W-1:0] {
    FN_PASS = 5'b00000,
    FN_INC  = 5'b00001,
    FN_ADD  = 5'b00010,
    FN_SUB  = 5'b00101,
    FN_DEC  = 5'b00110,
    FN_AND  = 5'b01000,
    FN_OR   = 5'b01010,
    FN_XOR  = 5'b01100,
    FN_NOT  = 5'b01110,
    FN_SHR  = 5'b10000,
    FN_SHL  = 5'b11000
  } alu_fn_e;

endpackage

// File: rtl/cw_src_mux.sv
module cw_src_mux
  import cw_dp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [SEL_W-1:0]           sel,
  input  logic [DW-1:0]              ext_in,
  input  logic [NREG-1:0][DW-1:0]    regs,
  output logic [DW-1:0]              bus
);

  // code 0 routes the external operand, code k routes register k
  always_comb begin
    bus = ext_in;
    for (int k = 1; k <= int'(NREG); k++) begin
      if (sel == SEL_W'(k)) bus = regs[k-1];
    end
  end

endmodule

// File: rtl/cw_alu.sv
module cw_alu
  import cw_dp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [FN_W-1:0] fn,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   y
);

  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    case (alu_fn_e'(fn))
      FN_PASS: y = a;
      FN_INC:  y = a + ONE;
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_DEC:  y = a - ONE;
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_XOR:  y = a ^ b;
      FN_NOT:  y = ~a;
      FN_SHR:  y = {1'b0, a[DW-1:1]};
      FN_SHL:  y = {a[DW-2:0], 1'b0};
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/cw_regbank.sv
module cw_regbank
  import cw_dp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SEL_W-1:0]           dest,
  input  logic [DW-1:0]              wdata,
  output logic [NREG-1:0][DW-1:0]    regs
);

  logic [NREG-1:0]             wr_en;
  logic [NREG-1:0][DW-1:0]     reg_d;
  logic [NREG-1:0][DW-1:0]     reg_q;

  // destination decoder: code k enables register k, code 0 enables none
  for (genvar k = 0; k < int'(NREG); k++) begin : g_dec
    assign wr_en[k] = (dest == SEL_W'(k + 1));

    always_comb begin
      reg_d[k] = reg_q[k];
      if (wr_en[k]) reg_d[k] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q[k] <= '0;
      else        reg_q[k] <= reg_d[k];
    end
  end

  assign regs = reg_q;

endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
  import cw_dp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW_W-1:0]   ctrl_word,
  input  logic [DW-1:0]     ext_in,
  output logic [DW-1:0]     result_out
);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // control word fields
  logic [1:0][SEL_W-1:0]  src_sel;
  logic [SEL_W-1:0]       dst_sel;
  logic [FN_W-1:0]        fn_sel;

  assign src_sel[0] = ctrl_word[A_LSB +: SEL_W];
  assign src_sel[1] = ctrl_word[B_LSB +: SEL_W];
  assign dst_sel    = ctrl_word[D_LSB +: SEL_W];
  assign fn_sel     = ctrl_word[FN_W-1:0];

  logic [NREG-1:0][DW-1:0] reg_q;
  logic [1:0][DW-1:0]      bus;
  logic [DW-1:0]           alu_y;

  for (genvar g = 0; g < 2; g++) begin : g_bus
    cw_src_mux #(.DW(DW)) u_mux (
      .sel    (src_sel[g]),
      .ext_in (ext_in),
      .regs   (reg_q),
      .bus    (bus[g])
    );
  end

  cw_alu #(.DW(DW)) u_alu (
    .fn (fn_sel),
    .a  (bus[0]),
    .b  (bus[1]),
    .y  (alu_y)
  );

  cw_regbank #(.DW(DW)) u_bank (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .dest  (dst_sel),
    .wdata (alu_y),
    .regs  (reg_q)
  );

  assign result_out = alu_y;

endmodule

// File: rtl/cw_datapath_chk.sv
module cw_datapath_chk
  import cw_dp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                     clk,
  input  logic                     rst_sync_n,
  input  logic [CW_W-1:0]          ctrl_word,
  input  logic [DW-1:0]            ext_in,
  input  logic [DW-1:0]            result_out,
  input  logic [NREG-1:0][DW-1:0]  regs
);

  logic [SEL_W-1:0] a_f, b_f, d_f;
  logic [FN_W-1:0]  fn_f;
  logic             armed;

  assign a_f  = ctrl_word[A_LSB +: SEL_W];
  assign b_f  = ctrl_word[B_LSB +: SEL_W];
  assign d_f  = ctrl_word[D_LSB +: SEL_W];
  assign fn_f = ctrl_word[FN_W-1:0];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) armed <= 1'b0;
    else             armed <= 1'b1;
  end

  for (genvar k = 0; k < int'(NREG); k++) begin : g_reg
    // R3
    reg_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (armed && d_f == SEL_W'(k + 1)) |=> regs[k] == $past(result_out));
    // R3
    reg_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (armed && d_f != SEL_W'(k + 1)) |=> $stable(regs[k]));
  end

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> regs == '0);

  // R2
  ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (a_f == '0 && fn_f == FN_PASS) |-> result_out == ext_in);

  // R7
  unlisted_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(fn_f inside {FN_PASS, FN_INC, FN_ADD, FN_SUB, FN_DEC, FN_AND,
                   FN_OR, FN_XOR, FN_NOT, FN_SHR, FN_SHL}) |-> result_out == '0);

  // R10
  self_xor_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fn_f == FN_XOR && a_f == b_f) |-> result_out == '0);

  // R6
  shr_fill_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fn_f == FN_SHR) |-> result_out[DW-1] == 1'b0);

  // R6
  shl_fill_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fn_f == FN_SHL) |-> result_out[0] == 1'b0);

endmodule

bind cw_datapath cw_datapath_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .ctrl_word  (ctrl_word),
  .ext_in     (ext_in),
  .result_out (result_out),
  .regs       (reg_q)
);

// File: tb/sim_cw_datapath.sv
`timescale 1ns/1ps
module sim_cw_datapath;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] ctrl_word = '0;
  logic [7:0]  ext_in = '0;
  logic [7:0]  result_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mdl [1:7];

  always #2.5 clk = ~clk;

  cw_datapath u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_word  (ctrl_word),
    .ext_in     (ext_in),
    .result_out (result_out)
  );

  function automatic logic [7:0] src_of(input logic [2:0] s, input logic [7:0] x);
    return (s == 3'd0) ? x : mdl[s];
  endfunction

  function automatic logic [7:0] alu_of(input logic [4:0] f,
                                        input logic [7:0] a, input logic [7:0] b);
    case (f)
      5'b00000: return a;
      5'b00001: return a + 8'd1;
      5'b00010: return a + b;
      5'b00101: return a - b;
      5'b00110: return a - 8'd1;
      5'b01000: return a & b;
      5'b01010: return a | b;
      5'b01100: return a ^ b;
      5'b01110: return ~a;
      5'b10000: return a >> 1;
      5'b11000: return a << 1;
      default:  return 8'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] f);
    case (f)
      5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110: return "R4";
      5'b01000, 5'b01010, 5'b01100, 5'b01110:           return "R5";
      5'b10000, 5'b11000:                               return "R6";
      default:                                          return "R7";
    endcase
  endfunction

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: result_out=%02h expected=%02h at %0t", tag, got, exp, $time);
    end
  endtask

  // drive one word at the falling edge, check the output before the rising edge
  task automatic issue(input logic [2:0] a, input logic [2:0] b, input logic [2:0] d,
                       input logic [4:0] f, input logic [7:0] x, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    ctrl_word = {a, b, d, f};
    ext_in    = x;
    #1;
    exp = alu_of(f, src_of(a, x), src_of(b, x));
    check(result_out, exp, tag);
    @(posedge clk);
    if (d != 3'd0) mdl[d] = exp;
  endtask

  task automatic read_all(input string tag);
    for (int k = 1; k <= 7; k++) issue(3'(k), 3'd0, 3'd0, 5'b00000, 8'h00, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ctrl_word = '0;
    for (int k = 1; k <= 7; k++) mdl[k] = 8'h00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [4:0] fn_list [11] = '{5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110,
                                5'b01000, 5'b01010, 5'b01100, 5'b01110, 5'b10000, 5'b11000};
    void'($urandom(32'h5EED_C0DE));
    do_reset();

    // R9: every register reads zero after reset
    read_all("R9");

    // R2: external operand on A, then on B
    issue(3'd0, 3'd0, 3'd1, 5'b00000, 8'hA5, "R2");
    issue(3'd1, 3'd0, 3'd2, 5'b00010, 8'h11, "R2");
    issue(3'd0, 3'd0, 3'd3, 5'b00000, 8'h3C, "R2");
    // R1: 010_011_001_00101 computes R1 = R2 - R3 (0xB6 - 0x3C = 0x7A)
    issue(3'd2, 3'd3, 3'd1, 5'b00101, 8'h00, "R1");
    read_all("R1");

    // R4: wrap points
    issue(3'd0, 3'd0, 3'd4, 5'b00000, 8'hFF, "R4");
    issue(3'd4, 3'd0, 3'd5, 5'b00001, 8'h00, "R4");
    issue(3'd5, 3'd0, 3'd6, 5'b00110, 8'h00, "R4");
    issue(3'd5, 3'd4, 3'd7, 5'b00101, 8'h00, "R4");
    issue(3'd4, 3'd0, 3'd6, 5'b00010, 8'h01, "R4");

    // R6: end bits set, zero fill expected
    issue(3'd0, 3'd0, 3'd2, 5'b10000, 8'h81, "R6");
    issue(3'd0, 3'd0, 3'd3, 5'b11000, 8'h81, "R6");

    // R5: complement and bitwise
    issue(3'd0, 3'd0, 3'd4, 5'b01110, 8'h5A, "R5");
    issue(3'd4, 3'd0, 3'd5, 5'b01010, 8'h0F, "R5");

    // R7: unlisted codes next to listed ones
    issue(3'd4, 3'd5, 3'd0, 5'b00011, 8'hFF, "R7");
    issue(3'd4, 3'd5, 3'd0, 5'b11111, 8'hFF, "R7");
    issue(3'd4, 3'd5, 3'd0, 5'b01001, 8'hFF, "R7");

    // R8 / R3: destination 0 shows result but writes nothing
    issue(3'd0, 3'd0, 3'd0, 5'b00000, 8'hEE, "R8");
    read_all("R3");

    // R10: 101_101_101_01100 clears R5
    issue(3'd5, 3'd5, 3'd5, 5'b01100, 8'h00, "R10");
    issue(3'd5, 3'd0, 3'd0, 5'b00000, 8'h00, "R10");

    // random mix, mostly listed functions
    for (int i = 0; i < 400; i++) begin
      logic [4:0] f;
      if ($urandom_range(0, 9) == 0) f = 5'($urandom_range(0, 31));
      else                           f = fn_list[$urandom_range(0, 10)];
      issue(3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
            3'($urandom_range(0, 7)), f, 8'($urandom_range(0, 255)), tag_of(f));
      if (i % 50 == 49) read_all("R3");
    end

    // R9: reset in the middle of operation clears written registers
    do_reset();
    read_all("R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule